// File: doc/BRIEF.md
# Ethernet MII Receive Frame Check Sequence Checker

This block watches the 4-bit receive side of a media-independent interface and decides, for each frame, whether the trailing 32-bit frame check sequence is correct. It skips the run of `0x5` preamble nibbles and the `0xD` delimiter nibble. From the next nibble up to the last nibble before the data-valid line drops, it advances a CRC register four bits per clock. Data bits are taken in wire order, so `rxd_i[0]` is handled first.

The check sequence is never extracted from the stream. It is fed through the same CRC as the data. A frame is good when the register then holds the fixed residue `0xC704DD7B`. This value is compared directly, with no final inversion. The generator polynomial is 0x04C11DB7, applied most-significant-bit first. Each frame presets the register to all ones.

One clock after data-valid falls, the block raises a single-cycle done strobe. With it, it presents the verdict and the number of nibbles counted after the delimiter. Both values are held until the next verdict. A frame is always judged bad if any of these is true: a receive error was flagged inside it, its nibble count is odd, or it is shorter than eight nibbles.

Top module: `mii_fcs_checker`

## Requirements
- R1: After reset, `frame_done_o` and `fcs_ok_o` are low and `nib_count_o` is zero.
- R2: A frame starts when, with `rx_dv_i` high, one or more `0x5` nibbles are followed by a `0xD` nibble. Only the nibbles after `0xD` are counted and passed to the CRC. The reported count is the number of such nibbles, whatever the preamble length.
- R3: Each byte is received as its low nibble first, and `rxd_i[0]` of each nibble is the earliest bit. A frame whose last four bytes are the complemented, LSB-first CRC-32 of the bytes before them is reported with `fcs_ok_o` high.
- R4: A frame in which any data or check bit is altered is reported with `fcs_ok_o` low.
- R5: `frame_done_o` is high for exactly one cycle. That cycle is the first clock edge at which `rx_dv_i` is sampled low inside a frame. `fcs_ok_o` and `nib_count_o` are updated in that same cycle and are held until the next frame ends.
- R6: If `rx_er_i` is high on any counted nibble of a frame, that frame is reported with `fcs_ok_o` low.
- R7: A frame with an odd nibble count is reported with `fcs_ok_o` low.
- R8: A frame with fewer than 8 counted nibbles is reported with `fcs_ok_o` low. A correct frame of exactly 8 nibbles (a check sequence alone) is reported good.
- R9: A burst of `rx_dv_i` with no valid preamble-then-`0xD` opening produces no `frame_done_o` pulse. This covers a burst that contains a nibble other than `0x5` before `0xD`, and a burst that ends during the preamble.
- R10: The CRC register is preset to all ones at every delimiter. A frame's verdict therefore does not depend on any earlier frame, including a short or corrupted one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_dv_i | input | 1 | Receive data valid |
| rxd_i | input | 4 | Receive nibble, bit 0 earliest on the wire |
| rx_er_i | input | 1 | Receive error flag |
| frame_done_o | output | 1 | One-cycle strobe at frame end |
| fcs_ok_o | output | 1 | Verdict of the last frame, high when good |
| nib_count_o | output | CNT_W | Nibbles counted after the delimiter in the last frame (saturating) |

## Verification
On every cycle, the assertions check the following. The done strobe lasts a single cycle and appears only right after data-valid falls inside a frame. A verdict with an odd or short count, or with an error flagged, is never good. The CRC register is all ones on the cycle after a delimiter. Only the bench scenarios can show that the polynomial, bit order and residue actually match a serially computed CRC-32. These scenarios are randomly sized frames, corrupted bits, and preamble-only or malformed bursts. The same goes for the claim that one frame's state does not leak into the next.

// File: rtl/mii_fcs_pkg.sv
package mii_fcs_pkg;

  localparam logic [31:0] CRC_POLY    = 32'h04C1_1DB7;
  localparam logic [31:0] CRC_RESIDUE = 32'hC704_DD7B;
  localparam logic [3:0]  NIB_PRE     = 4'h5;
  localparam logic [3:0]  NIB_SFD     = 4'hD;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PRE  = 2'd1,
    ST_BODY = 2'd2,
    ST_DROP = 2'd3
  } rx_state_e;

  // Advance the CRC by one nibble; d[0] is the earliest bit on the wire.
  function automatic logic [31:0] crc_step_nib(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 0; i < 4; i++) begin
      fb = r[31] ^ d[i];
      r  = {r[30:0], 1'b0} ^ (fb ? CRC_POLY : 32'h0);
    end
    return r;
  endfunction

endpackage

// File: rtl/mii_sfd_tracker.sv
module mii_sfd_tracker
  import mii_fcs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_dv_i,
  input  logic [3:0] rxd_i,
  output logic       sfd_hit_o,
  output logic       body_nib_o,
  output logic       end_hit_o
);

  rx_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (rx_dv_i) st_d = (rxd_i == NIB_PRE) ? ST_PRE : ST_DROP;
      ST_PRE: begin
        if (!rx_dv_i)              st_d = ST_IDLE;
        else if (rxd_i == NIB_SFD) st_d = ST_BODY;
        else if (rxd_i != NIB_PRE) st_d = ST_DROP;
      end
      ST_BODY: if (!rx_dv_i) st_d = ST_IDLE;
      ST_DROP: if (!rx_dv_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign sfd_hit_o  = (st_q == ST_PRE)  &&  rx_dv_i && (rxd_i == NIB_SFD);
  assign body_nib_o = (st_q == ST_BODY) &&  rx_dv_i;
  assign end_hit_o  = (st_q == ST_BODY) && !rx_dv_i;

  // R9: a frame body is entered only through the preamble state
  a_r9_body_via_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_BODY) ##1 (st_q == ST_BODY) |-> $past(st_q) == ST_PRE);

endmodule

// File: rtl/mii_crc_nibble.sv
module mii_crc_nibble
  import mii_fcs_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        preset_i,
  input  logic        step_i,
  input  logic [3:0]  nib_i,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q, crc_d;
  logic        crc_en;

  assign crc_en = preset_i | step_i;

  always_comb begin
    crc_d = crc_q;
    if (preset_i)    crc_d = '1;
    else if (step_i) crc_d = crc_step_nib(crc_q, nib_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

  // R10: every delimiter leaves the register preset to all ones
  a_r10_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    preset_i |=> crc_q == 32'hFFFF_FFFF);

endmodule

// File: rtl/mii_frame_stats.sv
module mii_frame_stats #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             nib_i,
  input  logic             rx_er_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             err_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             err_q, err_d;
  logic             stat_en;

  assign stat_en = clear_i | nib_i;

  always_comb begin
    cnt_d = cnt_q;
    err_d = err_q;
    if (clear_i) begin
      cnt_d = '0;
      err_d = 1'b0;
    end else if (nib_i) begin
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      err_d = err_q | rx_er_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      err_q <= 1'b0;
    end else if (stat_en) begin
      cnt_q <= cnt_d;
      err_q <= err_d;
    end
  end

  assign cnt_o = cnt_q;
  assign err_o = err_q;

  // R6: an error seen on a counted nibble sticks until the next frame opens
  a_r6_err_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !clear_i) |=> err_q);

endmodule

// File: rtl/mii_fcs_checker.sv
module mii_fcs_checker
  import mii_fcs_pkg::*;
#(
  parameter int CNT_W    = 12,
  parameter int MIN_NIBS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_dv_i,
  input  logic [3:0]       rxd_i,
  input  logic             rx_er_i,
  output logic             frame_done_o,
  output logic             fcs_ok_o,
  output logic [CNT_W-1:0] nib_count_o
);

  localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_NIBS);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  logic             sfd_hit, body_nib, end_hit;
  logic [31:0]      crc_val;
  logic [CNT_W-1:0] cnt_val;
  logic             err_val;

  mii_sfd_tracker u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .rx_dv_i    (rx_dv_i),
    .rxd_i      (rxd_i),
    .sfd_hit_o  (sfd_hit),
    .body_nib_o (body_nib),
    .end_hit_o  (end_hit)
  );

  mii_crc_nibble u_crc (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .preset_i (sfd_hit),
    .step_i   (body_nib),
    .nib_i    (rxd_i),
    .crc_o    (crc_val)
  );

  mii_frame_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_int),
    .clear_i (sfd_hit),
    .nib_i   (body_nib),
    .rx_er_i (rx_er_i),
    .cnt_o   (cnt_val),
    .err_o   (err_val)
  );

  logic             done_q, ok_q, ok_d;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    ok_d = (crc_val == CRC_RESIDUE) && !err_val && !cnt_val[0] && (cnt_val >= MIN_CNT);
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) done_q <= 1'b0;
    else            done_q <= end_hit;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      ok_q  <= 1'b0;
      cnt_q <= '0;
    end else if (end_hit) begin
      ok_q  <= ok_d;
      cnt_q <= cnt_val;
    end
  end

  assign frame_done_o = done_q;
  assign fcs_ok_o     = ok_q;
  assign nib_count_o  = cnt_q;

  // R5: strobe lasts one cycle
  a_r5_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    frame_done_o |=> !frame_done_o);
  // R5: strobe only follows a low data-valid
  a_r5_done_after_fall: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    frame_done_o |-> !$past(rx_dv_i));
  // R7: odd counts never pass
  a_r7_odd_bad: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (frame_done_o && nib_count_o[0]) |-> !fcs_ok_o);
  // R8: short frames never pass
  a_r8_short_bad: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (frame_done_o && (nib_count_o < MIN_CNT)) |-> !fcs_ok_o);
  // R5: verdict held between strobes
  a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !frame_done_o |-> $stable(fcs_ok_o) && $stable(nib_count_o));

endmodule

// File: tb/mii_fcs_checker_tb.sv
module mii_fcs_checker_tb_top;

  localparam int CNT_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             rx_dv = 1'b0;
  logic [3:0]       rxd = 4'h0;
  logic             rx_er = 1'b0;
  logic             frame_done;
  logic             fcs_ok;
  logic [CNT_W-1:0] nib_count;

  always #4 clk = ~clk;

  mii_fcs_checker #(.CNT_W(CNT_W), .MIN_NIBS(8)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .rx_dv_i      (rx_dv),
    .rxd_i        (rxd),
    .rx_er_i      (rx_er),
    .frame_done_o (frame_done),
    .fcs_ok_o     (fcs_ok),
    .nib_count_o  (nib_count)
  );

  int n_chk = 0;
  int n_bad = 0;
  int pulses = 0;
  int cycles = 0;
  bit finished = 0;

  logic [7:0] bytes [0:127];
  int         nbytes;
  logic [3:0] nibs [0:300];
  int         nnib;

  always @(negedge clk) if (frame_done) pulses++;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      summary();
    end
  end

  task automatic chk(input bit cond, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // serial, reflected CRC-32 over bytes[0:n-1]
  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    logic        fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++)
      for (int b = 0; b < 8; b++) begin
        fb = c[0] ^ bytes[k][b];
        c  = c >> 1;
        if (fb) c = c ^ 32'hEDB8_8320;
      end
    return c;
  endfunction

  // append check sequence and expand to nibbles, low nibble first
  task automatic build(input int payload);
    logic [31:0] f;
    f = ~ref_crc(payload);
    for (int k = 0; k < 4; k++) bytes[payload + k] = f[8*k +: 8];
    nbytes = payload + 4;
    nnib = 0;
    for (int k = 0; k < nbytes; k++) begin
      nibs[nnib] = bytes[k][3:0]; nnib++;
      nibs[nnib] = bytes[k][7:4]; nnib++;
    end
  endtask

  task automatic fill_random(input int payload);
    for (int k = 0; k < payload; k++) bytes[k] = 8'($urandom());
  endtask

  // drive one burst; er_idx < 0 for none
  task automatic send(input int pre_len, input bit with_sfd, input int er_idx);
    for (int k = 0; k < pre_len; k++) begin
      @(negedge clk); rx_dv = 1; rxd = 4'h5; rx_er = 0;
    end
    if (with_sfd) begin
      @(negedge clk); rxd = 4'hD;
      for (int k = 0; k < nnib; k++) begin
        @(negedge clk); rxd = nibs[k]; rx_er = (k == er_idx);
      end
    end
    @(negedge clk); rx_dv = 0; rxd = 4'h0; rx_er = 0;
  endtask

  // dv fell at the last negedge; strobe appears after next posedge
  task automatic expect_frame(input bit exp_ok, input int exp_cnt, input string tag);
    @(posedge clk); @(negedge clk);
    chk(frame_done == 1'b1, {tag, " R5 strobe"}, frame_done, 1);
    chk(fcs_ok == exp_ok, {tag, " verdict"}, fcs_ok, exp_ok);
    chk(nib_count == CNT_W'(exp_cnt), {tag, " R2 count"}, nib_count, exp_cnt);
    @(negedge clk);
    chk(frame_done == 1'b0, {tag, " R5 one cycle"}, frame_done, 0);
    chk(fcs_ok == exp_ok, {tag, " R5 hold"}, fcs_ok, exp_ok);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int p0;
    int len;
    int kind;
    int pos;
    bit eok;
    void'($urandom(32'd20240705));
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(frame_done == 0, "R1 done", frame_done, 0);
    chk(fcs_ok == 0, "R1 ok", fcs_ok, 0);
    chk(nib_count == 0, "R1 count", nib_count, 0);

    // R3 directed good frame, long preamble
    fill_random(46); build(46); send(15, 1, -1); expect_frame(1, 2 * 50, "R3 good");
    // R2 shortest preamble
    fill_random(10); build(10); send(1, 1, -1); expect_frame(1, 28, "R2 pre1");
    // R4 single flipped bit
    fill_random(20); build(20); nibs[7] = nibs[7] ^ 4'h4; send(7, 1, -1);
    expect_frame(0, 48, "R4 flip");
    // R10 good frame right after a corrupt one
    fill_random(12); build(12); send(7, 1, -1); expect_frame(1, 32, "R10 after bad");
    // R6 error flag inside body
    fill_random(16); build(16); send(7, 1, 5); expect_frame(0, 40, "R6 rx_er");
    // R7 extra trailing nibble
    fill_random(16); build(16); nibs[nnib] = 4'h0; nnib++; send(7, 1, -1);
    expect_frame(0, 41, "R7 odd");
    // R8 short frame then good frame
    nnib = 4; for (int k = 0; k < 4; k++) nibs[k] = 4'($urandom());
    send(7, 1, -1); expect_frame(0, 4, "R8 short");
    nnib = 0; send(7, 1, -1); expect_frame(0, 0, "R8 empty");
    build(0); send(7, 1, -1); expect_frame(1, 8, "R8 exact8");
    fill_random(8); build(8); send(7, 1, -1); expect_frame(1, 24, "R10 after short");

    // R9 malformed bursts: no strobe
    p0 = pulses;
    send(9, 0, -1); repeat (4) @(negedge clk);
    nnib = 3; nibs[0] = 4'h5; nibs[1] = 4'hD; nibs[2] = 4'h1;
    @(negedge clk); rx_dv = 1; rxd = 4'h5;
    @(negedge clk); rxd = 4'hA;
    for (int k = 0; k < 3; k++) begin @(negedge clk); rxd = nibs[k]; end
    @(negedge clk); rx_dv = 0; rxd = 0;
    repeat (4) @(negedge clk);
    @(negedge clk); rx_dv = 1; rxd = 4'hD;
    @(negedge clk); rxd = 4'h3;
    @(negedge clk); rx_dv = 0; rxd = 0;
    repeat (4) @(negedge clk);
    chk(pulses == p0, "R9 no strobe", pulses - p0, 0);
    // R10 state clean after malformed bursts
    fill_random(6); build(6); send(7, 1, -1); expect_frame(1, 20, "R10 after drop");

    // random mix
    for (int it = 0; it < 60; it++) begin
      len  = 1 + ($urandom() % 60);
      kind = $urandom() % 4;
      fill_random(len); build(len);
      eok = 1;
      pos = $urandom() % nnib;
      if (kind == 1) begin
        nibs[pos] = nibs[pos] ^ (4'h1 << ($urandom() % 4)); eok = 0;
        send(1 + ($urandom() % 15), 1, -1);
        expect_frame(eok, nnib, "R4 random");
      end else if (kind == 2) begin
        send(1 + ($urandom() % 15), 1, pos);
        expect_frame(0, nnib, "R6 random");
      end else begin
        send(1 + ($urandom() % 15), 1, -1);
        expect_frame(1, nnib, "R3 random");
      end
    end

    finished = 1;
    summary();
  end

endmodule